// File: doc/BRIEF.md
# Packed Unsigned Halving Add/Subtract Unit

This unit is one execute-stage datapath slice. It takes two 32-bit operands and returns their packed unsigned halving sum or difference. A 3-bit selector picks one of two lane layouts.

- **16-bit layout.** The word splits into two halfword lanes. Besides straight add and straight subtract, two crossed variants pair each halfword of the first operand with the opposite halfword of the second. One lane adds and the other subtracts.
- **8-bit layout.** The word splits into four byte lanes. All four lanes either add or subtract.

Every lane works one bit wider than its width, so a carry or borrow is kept. The lane then shifts right by one and keeps its own width. The lanes are packed with lane 0 in the least significant bits.

A 4-bit condition code gates execution. Code 0xE always executes. Any other code executes only when the external condition-pass flag is high. When the operation executes, the registered result appears one clock later with a write-enable. When it does not execute, or the selector is unsupported, the write-enable stays low and the result is zero. The register file and the flags are outside this unit.

Top module: `packed_halving_alu`

## Requirements
- R1: While reset (rst_n low) is asserted, result is 0 and wr_en is 0.
- R2: Selector 0 (dual add, 16-bit): each halfword lane is (a_lane + b_lane + carry kept) >> 1, truncated to 16 bits. Lane 0 is bits 15:0.
- R3: Selector 3 (dual subtract, 16-bit): each halfword lane is the 17-bit difference a_lane - b_lane shifted right by one. A borrow sets the lane MSB, so 0 - 2 gives 0xFFFF.
- R4: Selector 1: the low halfword is (a[15:0] - b[31:16]) >> 1 and the high halfword is (a[31:16] + b[15:0]) >> 1, both at 17-bit precision.
- R5: Selector 2: the low halfword is (a[15:0] + b[31:16]) >> 1 and the high halfword is (a[31:16] - b[15:0]) >> 1, both at 17-bit precision.
- R6: Selector 4: each of the four byte lanes is (a_byte + b_byte) >> 1 at 9-bit precision. Byte lane 0 is bits 7:0.
- R7: Selector 7: each of the four byte lanes is the 9-bit difference a_byte - b_byte shifted right by one. A borrow sets the byte MSB.
- R8: Condition code 0xE executes with a supported selector whatever the value of cond_pass.
- R9: A condition code other than 0xE executes only when cond_pass is 1. Otherwise wr_en is 0 and result is 0.
- R10: Selectors 5 and 6 never execute: wr_en is 0 and result is 0.
- R11: result and wr_en are registered. They reflect the inputs present at the previous rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand (minuend for subtract lanes) |
| op_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation selector |
| cond | input | 4 | Condition code; 0xE means always |
| cond_pass | input | 1 | External condition evaluation result |
| result | output | 32 | Packed halved lanes; zero when not written |
| wr_en | output | 1 | Destination write-enable |

## Verification
Every result and write-enable is due exactly one rising edge after its inputs are applied. The bench changes inputs on a falling edge and compares on the next falling edge, half a period after the capturing edge. Just after applying new inputs, it also confirms that the outputs still show the previous operation, which proves the single register stage. Table vectors, directed condition and selector cases, and random operands drawn against a lane-by-lane reference model all follow this one-cycle pattern.

// File: rtl/phalf_pkg.sv
package phalf_pkg;

    typedef enum logic [2:0] {
        PH_ADD16 = 3'd0,
        PH_ASX   = 3'd1,
        PH_SAX   = 3'd2,
        PH_SUB16 = 3'd3,
        PH_ADD8  = 3'd4,
        PH_SUB8  = 3'd7
    } phalf_op_e;

    localparam logic [3:0] COND_ALWAYS = 4'hE;

endpackage

// File: rtl/phalf_lane.sv
module phalf_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    output logic [W-1:0] z
);
    logic [W:0] wide;

    always_comb begin
        if (sub) wide = {1'b0, x} - {1'b0, y};
        else     wide = {1'b0, x} + {1'b0, y};
        z = wide[W:1];
    end
endmodule

// File: rtl/phalf_cond_gate.sv
module phalf_cond_gate
    import phalf_pkg::*;
(
    input  logic [3:0] cond,
    input  logic       cond_pass,
    output logic       go
);
    always_comb go = (cond == COND_ALWAYS) || cond_pass;
endmodule

// File: rtl/packed_halving_alu.sv
module packed_halving_alu
    import phalf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        op_sel,
    input  logic [3:0]        cond,
    input  logic              cond_pass,
    output logic [DATA_W-1:0] result,
    output logic              wr_en
);
    localparam int HALF_W = DATA_W / 2;
    localparam int NBYTE  = DATA_W / BYTE_W;

    logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [HALF_W-1:0] y_lo, y_hi, z_lo, z_hi;
    logic              exch, sub_lo, sub_hi, sub_b;
    logic              is_half, is_byte, go;
    logic [DATA_W-1:0] half_res, byte_res;
    logic [DATA_W-1:0] res_d;
    logic              we_d;

    assign a_lo = op_a[HALF_W-1:0];
    assign a_hi = op_a[DATA_W-1:HALF_W];
    assign b_lo = op_b[HALF_W-1:0];
    assign b_hi = op_b[DATA_W-1:HALF_W];

    always_comb begin
        exch    = (op_sel == PH_ASX) || (op_sel == PH_SAX);
        sub_lo  = (op_sel == PH_ASX) || (op_sel == PH_SUB16);
        sub_hi  = (op_sel == PH_SAX) || (op_sel == PH_SUB16);
        sub_b   = (op_sel == PH_SUB8);
        is_half = (op_sel == PH_ADD16) || (op_sel == PH_ASX) ||
                  (op_sel == PH_SAX)   || (op_sel == PH_SUB16);
        is_byte = (op_sel == PH_ADD8)  || (op_sel == PH_SUB8);
        y_lo    = exch ? b_hi : b_lo;
        y_hi    = exch ? b_lo : b_hi;
    end

    phalf_lane #(.W(HALF_W)) u_lane_lo (.x(a_lo), .y(y_lo), .sub(sub_lo), .z(z_lo));
    phalf_lane #(.W(HALF_W)) u_lane_hi (.x(a_hi), .y(y_hi), .sub(sub_hi), .z(z_hi));
    assign half_res = {z_hi, z_lo};

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        phalf_lane #(.W(BYTE_W)) u_lane_b (
            .x   (op_a[i*BYTE_W +: BYTE_W]),
            .y   (op_b[i*BYTE_W +: BYTE_W]),
            .sub (sub_b),
            .z   (byte_res[i*BYTE_W +: BYTE_W])
        );
    end

    phalf_cond_gate u_gate (.cond(cond), .cond_pass(cond_pass), .go(go));

    always_comb begin
        we_d  = go && (is_half || is_byte);
        res_d = '0;
        if (we_d) res_d = is_half ? half_res : byte_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            wr_en  <= 1'b0;
        end else begin
            result <= res_d;
            wr_en  <= we_d;
        end
    end
endmodule

// File: rtl/phalf_checker.sv
module phalf_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_sel,
    input logic [3:0]        cond,
    input logic              cond_pass,
    input logic [DATA_W-1:0] result,
    input logic              wr_en
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !wr_en));

    a_r10_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd5 || op_sel == 3'd6) |=> (!wr_en && result == '0));

    a_r9_cond_fail: assert property (@(posedge clk) disable iff (!rst_n)
        (cond != 4'hE && !cond_pass) |=> (!wr_en && result == '0));

    a_r8_always_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hE && op_sel != 3'd5 && op_sel != 3'd6) |=> wr_en);

    a_r11_write_implies_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> ($past(cond) == 4'hE || $past(cond_pass)));
endmodule

bind packed_halving_alu phalf_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .cond(cond),
    .cond_pass(cond_pass), .result(result), .wr_en(wr_en)
);

// File: tb/packed_halving_alu_bench.sv
module packed_halving_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [2:0]  op_sel = '0;
    logic [3:0]  cond = 4'hE;
    logic        cond_pass = 1'b0;
    logic [31:0] result;
    logic        wr_en;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    packed_halving_alu u_packed_halving_alu (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .cond(cond), .cond_pass(cond_pass), .result(result), .wr_en(wr_en)
    );

    // {sel, a, b, expected}
    localparam logic [98:0] VEC [8] = '{
        {3'd0, 32'h0004_0006, 32'h0002_0002, 32'h0003_0004},
        {3'd0, 32'hFFFF_FFFF, 32'hFFFF_0001, 32'hFFFF_8000},
        {3'd3, 32'h0000_0010, 32'h0002_0004, 32'hFFFF_0006},
        {3'd1, 32'h0010_0020, 32'h0008_0004, 32'h000A_000C},
        {3'd2, 32'h0010_0020, 32'h0008_0004, 32'h0006_0014},
        {3'd4, 32'hFF10_0203, 32'hFF20_0401, 32'hFF18_0302},
        {3'd7, 32'h0010_0805, 32'h0100_0201, 32'hFF08_0302},
        {3'd1, 32'h0000_0000, 32'h0002_0000, 32'h0000_FFFF}
    };
    localparam string VREQ [8] = '{"R2", "R2", "R3", "R4", "R5", "R6", "R7", "R4"};

    function automatic logic [31:0] ref_model(logic [2:0] s, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = '0;
        logic [16:0] t;
        logic [8:0]  u;
        logic [15:0] al, ah, bl, bh;
        al = a[15:0]; ah = a[31:16]; bl = b[15:0]; bh = b[31:16];
        case (s)
            3'd0: begin t = al + bl; r[15:0] = t[16:1]; t = ah + bh; r[31:16] = t[16:1]; end
            3'd1: begin t = al - bh; r[15:0] = t[16:1]; t = ah + bl; r[31:16] = t[16:1]; end
            3'd2: begin t = al + bh; r[15:0] = t[16:1]; t = ah - bl; r[31:16] = t[16:1]; end
            3'd3: begin t = al - bl; r[15:0] = t[16:1]; t = ah - bh; r[31:16] = t[16:1]; end
            3'd4, 3'd7: begin
                for (int k = 0; k < 4; k++) begin
                    if (s == 3'd4) u = {1'b0, a[k*8 +: 8]} + {1'b0, b[k*8 +: 8]};
                    else           u = {1'b0, a[k*8 +: 8]} - {1'b0, b[k*8 +: 8]};
                    r[k*8 +: 8] = u[8:1];
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [31:0] exp_r, logic exp_w);
        checks++;
        if (result !== exp_r || wr_en !== exp_w) begin
            errors++;
            $display("FAIL %s: result=%h wr_en=%b expected result=%h wr_en=%b",
                     req, result, wr_en, exp_r, exp_w);
        end
    endtask

    // drive at a falling edge, compare one period later
    task automatic run(string req, logic [2:0] s, logic [31:0] a, logic [31:0] b,
                       logic [3:0] c, logic p, logic [31:0] exp_r, logic exp_w);
        @(negedge clk);
        op_sel = s; op_a = a; op_b = b; cond = c; cond_pass = p;
        @(negedge clk);
        check(req, exp_r, exp_w);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        op_sel = 3'd0; op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1", 32'h0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++)
            run(VREQ[i], VEC[i][98:96], VEC[i][95:64], VEC[i][63:32], 4'hE, 1'b0,
                VEC[i][31:0], 1'b1);

        run("R3", 3'd3, 32'h0000_FFFF, 32'hFFFF_0000, 4'hE, 1'b0,
            ref_model(3'd3, 32'h0000_FFFF, 32'hFFFF_0000), 1'b1);
        run("R6", 3'd4, 32'hFF00_FF00, 32'hFF00_00FF, 4'hE, 1'b0, 32'hFF00_7F7F, 1'b1);
        run("R7", 3'd7, 32'h00FF_0000, 32'hFF00_00FF, 4'hE, 1'b0, 32'h807F_0080, 1'b1);

        run("R9", 3'd0, 32'h0004_0006, 32'h0002_0002, 4'h0, 1'b0, 32'h0, 1'b0);
        run("R9", 3'd0, 32'h0004_0006, 32'h0002_0002, 4'h0, 1'b1, 32'h0003_0004, 1'b1);
        run("R8", 3'd4, 32'h0202_0202, 32'h0202_0202, 4'hE, 1'b0, 32'h0202_0202, 1'b1);
        run("R9", 3'd7, 32'h1111_1111, 32'h0101_0101, 4'hF, 1'b0, 32'h0, 1'b0);
        run("R10", 3'd5, 32'h1234_5678, 32'h1111_1111, 4'hE, 1'b1, 32'h0, 1'b0);
        run("R10", 3'd6, 32'h1234_5678, 32'h1111_1111, 4'hE, 1'b1, 32'h0, 1'b0);

        // R11: new inputs must not reach the outputs before the next rising edge
        run("R11", 3'd0, 32'h0004_0006, 32'h0002_0002, 4'hE, 1'b0, 32'h0003_0004, 1'b1);
        @(negedge clk);
        op_sel = 3'd3; op_a = 32'h0; op_b = 32'h0002_0002; cond = 4'hE;
        #1 check("R11", 32'h0003_0004, 1'b1);
        @(negedge clk);
        check("R11", 32'hFFFF_FFFF, 1'b1);

        for (int i = 0; i < 300; i++) begin
            logic [2:0]  s;
            logic [31:0] a, b;
            s = 3'($urandom_range(0, 5));
            if (s == 3'd5) s = 3'd7;
            a = $urandom; b = $urandom;
            if (i % 5 == 0) a = 32'h0000_FFFF;
            if (i % 7 == 0) b = 32'hFF00_FFFF;
            run(s < 3'd4 ? "R2-5 rand" : "R6/7 rand", s, a, b, 4'hE, 1'b0,
                ref_model(s, a, b), 1'b1);
        end

        @(negedge clk);
        rst_n = 1'b0;
        #1 check("R1", 32'h0, 1'b0);
        finish_run();
    end
endmodule